// File: doc/BRIEF.md
# Data Path Wait Timeout Timer

This block watches a card host data path while it waits on the card. Software programs a 32-bit timeout period, counted in card bus clock periods. When the data path controller enters either of its two waiting conditions (waiting for read data from the card, or waiting while the card signals busy), a down-counter is loaded with that period. The counter then steps down once for each card bus clock. If the count runs out while the controller is still waiting, a sticky timeout flag is raised.

The block runs on the system clock. A one-cycle enable (`card_tick_i`) marks each card bus clock period. The two waiting conditions arrive as level inputs, and the block detects entry into each one itself. Software must program the period before it starts a transfer. A write made while a count is running only affects the next entry. There is no streaming data at this block's edge, so every pin is a plain control or status level, with no valid/ready handshake and no back-pressure.

Top module: `data_wait_timer`

## Requirements
- R1: After reset the period register reads 0 and `timeout_o` is 0.
- R2: A cycle with `cfg_wr_i` high stores `cfg_wdata_i` into the 32-bit period register. `cfg_rdata_o` shows the stored value from the next cycle onward.
- R3: A rising edge on `rd_wait_i` or on `busy_i` is an entry. An entry loads the counter with the period register value, and this holds when the controller moves straight from one waiting input to the other.
- R4: While a waiting input is high, only cycles with `card_tick_i` high decrement the count. For a period N of 1 or more, `timeout_o` goes high right after the Nth counted tick following entry.
- R5: A period of 0 raises `timeout_o` right after the first counted tick following entry.
- R6: When both waiting inputs are low, the count stops and no timeout is raised. A later entry restarts from the full period.
- R7: `timeout_o` stays high until a cycle with `flag_clr_i` high clears it. If a timeout fires in the same cycle as a clear, the flag ends up set.
- R8: A register write during a count does not change that count. The new value is used at the next entry. A write in the same cycle as an entry loads the old value.
- R9: After a timeout the counter holds at zero and stops counting. Clearing the flag while the controller is still waiting does not raise it again.
- R10: In an entry cycle the load takes priority, so a tick in that same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_tick_i | input | 1 | One-cycle pulse per card bus clock period |
| rd_wait_i | input | 1 | Controller is waiting for read data |
| busy_i | input | 1 | Controller is waiting while the card is busy |
| cfg_wr_i | input | 1 | Write strobe for the period register |
| cfg_wdata_i | input | 32 | Period value to write |
| cfg_rdata_o | output | 32 | Current period register value |
| flag_clr_i | input | 1 | Clears the timeout flag |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
Three pairs of events can land in the same cycle: a timeout firing and a flag clear, an entry and a card tick, and a register write and an entry. Directed steps force each pair together on purpose. The timeout-and-clear case must leave the flag set. The entry-and-tick case must not count the tick, which shows up as the flag staying low in the cycle where a period of 0 would otherwise have fired. The write-and-entry case is judged by when the flag finally rises. A random phase toggles the waiting inputs, ticks, writes and clears independently, so these overlaps also occur unplanned, and a reference model checks the flag and the register value in every cycle.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_RUN     = 2'd1,
    PH_EXPIRED = 2'd2
  } phase_e;
endpackage

// File: rtl/dwt_period_reg.sv
module dwt_period_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] period_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     period_o <= '0;
    else if (wr_en) period_o <= wr_data;
  end
endmodule

// File: rtl/dwt_entry_det.sv
module dwt_entry_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] state_i,
  output logic         entry_o,
  output logic         waiting_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise[g] = state_i[g] & ~prev_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= state_i;
  end

  assign entry_o   = |rise;
  assign waiting_o = |state_i;
endmodule

// File: rtl/dwt_countdown.sv
module dwt_countdown
  import dwt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         entry_i,
  input  logic         waiting_i,
  input  logic         tick_i,
  input  logic [W-1:0] period_i,
  output logic         fire_o,
  output logic [W-1:0] cnt_o,
  output phase_e       phase_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  phase_e       phase_q;

  always_comb begin
    fire_o = !entry_i && waiting_i && (phase_q == PH_RUN) && tick_i && (cnt_q <= ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_IDLE;
    end else if (entry_i) begin
      cnt_q   <= period_i;
      phase_q <= PH_RUN;
    end else if (!waiting_i) begin
      phase_q <= PH_IDLE;
    end else if (fire_o) begin
      cnt_q   <= '0;
      phase_q <= PH_EXPIRED;
    end else if (phase_q == PH_RUN && tick_i) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/dwt_flag.sv
module dwt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/data_wait_timer.sv
module data_wait_timer
  import dwt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_tick_i,
  input  logic             rd_wait_i,
  input  logic             busy_i,
  input  logic             cfg_wr_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  output logic [CNT_W-1:0] cfg_rdata_o,
  input  logic             flag_clr_i,
  output logic             timeout_o
);
  localparam int N_WAIT = 2;

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt;
  logic             entry;
  logic             waiting;
  logic             fire;
  phase_e           phase;

  dwt_period_reg #(.W(CNT_W)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_i),
    .wr_data  (cfg_wdata_i),
    .period_o (period_q)
  );

  dwt_entry_det #(.N(N_WAIT)) u_entry (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_i   ({busy_i, rd_wait_i}),
    .entry_o   (entry),
    .waiting_o (waiting)
  );

  dwt_countdown #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry_i   (entry),
    .waiting_i (waiting),
    .tick_i    (card_tick_i),
    .period_i  (period_q),
    .fire_o    (fire),
    .cnt_o     (cnt),
    .phase_o   (phase)
  );

  dwt_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (fire),
    .clr_i  (flag_clr_i),
    .flag_o (timeout_o)
  );

  assign cfg_rdata_o = period_q;
endmodule

// File: rtl/dwt_chk.sv
module dwt_chk
  import dwt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             card_tick_i,
  input logic             rd_wait_i,
  input logic             busy_i,
  input logic             flag_clr_i,
  input logic             timeout_o,
  input logic [CNT_W-1:0] period_q,
  input logic [CNT_W-1:0] cnt,
  input logic             entry,
  input logic             fire,
  input phase_e           phase
);
  // R3: an entry loads the period that was held at that edge
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (cnt == $past(period_q)));

  // R4: one counted tick removes exactly one from a running count above one
  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry && (rd_wait_i || busy_i) && phase == PH_RUN && card_tick_i && cnt > CNT_W'(1))
    |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R6: the flag can only rise after a counted tick while waiting
  a_r6_rise_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> ($past(rd_wait_i || busy_i) && $past(card_tick_i)));

  // R7: sticky until cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !flag_clr_i) |=> timeout_o);

  // R7: a firing timeout beats a clear in the same cycle
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> timeout_o);

  // R8: without an entry or a tick the count does not move, writes included
  a_r8_no_disturb: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry && !card_tick_i) |=> $stable(cnt));

  // R9: an expired count sits at zero
  a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXPIRED) |-> (cnt == '0));
endmodule

bind data_wait_timer dwt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .card_tick_i (card_tick_i),
  .rd_wait_i   (rd_wait_i),
  .busy_i      (busy_i),
  .flag_clr_i  (flag_clr_i),
  .timeout_o   (timeout_o),
  .period_q    (period_q),
  .cnt         (cnt),
  .entry       (entry),
  .fire        (fire),
  .phase       (phase)
);

// File: tb/tb_data_wait_timer.sv
`timescale 1ns/1ps
module tb_data_wait_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card_tick_i = 1'b0;
  logic        rd_wait_i = 1'b0;
  logic        busy_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        flag_clr_i = 1'b0;
  logic        timeout_o;

  int total = 0;
  int bad = 0;

  // reference model state
  logic [31:0] m_period = '0;
  logic [31:0] m_cnt = '0;
  int          m_ph = 0;
  logic        m_flag = 1'b0;
  logic        m_rwq = 1'b0;
  logic        m_bzq = 1'b0;

  always #2.5 clk = ~clk;

  data_wait_timer dut (
    .clk(clk), .rst_n(rst_n), .card_tick_i(card_tick_i),
    .rd_wait_i(rd_wait_i), .busy_i(busy_i), .cfg_wr_i(cfg_wr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .flag_clr_i(flag_clr_i), .timeout_o(timeout_o)
  );

  task automatic model_edge(input logic rw, input logic bz, input logic tk,
                            input logic wr, input logic [31:0] wd, input logic clr);
    logic ent, wt, fr;
    ent = (rw && !m_rwq) || (bz && !m_bzq);
    wt  = rw || bz;
    fr  = !ent && wt && (m_ph == 1) && tk && (m_cnt <= 32'd1);
    if (ent) begin m_cnt = m_period; m_ph = 1; end
    else if (!wt) m_ph = 0;
    else if (fr) begin m_cnt = '0; m_ph = 2; end
    else if (m_ph == 1 && tk) m_cnt = m_cnt - 32'd1;
    if (fr) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    if (wr) m_period = wd;
    m_rwq = rw;
    m_bzq = bz;
  endtask

  task automatic step(input logic rw, input logic bz, input logic tk,
                      input logic wr, input logic [31:0] wd, input logic clr);
    rd_wait_i = rw; busy_i = bz; card_tick_i = tk;
    cfg_wr_i = wr; cfg_wdata_i = wd; flag_clr_i = clr;
    @(posedge clk);
    model_edge(rw, bz, tk, wr, wd, clr);
    #1;
  endtask

  task automatic chk_flag(input string req, input logic exp);
    total++;
    if (timeout_o !== exp) begin
      bad++;
      $display("FAIL %s timeout_o actual=%b expected=%b at %0t", req, timeout_o, exp, $time);
    end
  endtask

  task automatic chk_rd(input string req, input logic [31:0] exp);
    total++;
    if (cfg_rdata_o !== exp) begin
      bad++;
      $display("FAIL %s cfg_rdata_o actual=%h expected=%h at %0t", req, cfg_rdata_o, exp, $time);
    end
  endtask

  task automatic clear_all();
    step(0, 0, 0, 0, '0, 1);
    step(0, 0, 0, 0, '0, 0);
  endtask

  initial begin : watchdog
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic rw, bz;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk_rd("R1", 32'h0);
    chk_flag("R1", 1'b0);

    // R2: write and read back
    step(0, 0, 0, 1, 32'hA5A5_3C3C, 0);
    chk_rd("R2", 32'hA5A5_3C3C);

    // R3/R4: period 3 on read wait, idle cycles in between
    step(0, 0, 0, 1, 32'd3, 0);
    step(1, 0, 0, 0, '0, 0);
    step(1, 0, 1, 0, '0, 0); chk_flag("R4 tick1", 1'b0);
    step(1, 0, 0, 0, '0, 0); chk_flag("R4 idle", 1'b0);
    step(1, 0, 1, 0, '0, 0); chk_flag("R4 tick2", 1'b0);
    step(1, 0, 0, 0, '0, 0); chk_flag("R4 idle", 1'b0);
    step(1, 0, 1, 0, '0, 0); chk_flag("R4 tick3", 1'b1);

    // R9: clear while still waiting, no re-fire
    step(1, 0, 0, 0, '0, 1); chk_flag("R7 clear", 1'b0);
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 1, 0, '0, 0);
      chk_flag("R9 no refire", 1'b0);
    end
    clear_all();

    // R6: leave mid-count, then full reload on busy re-entry
    step(0, 1, 0, 0, '0, 0);
    step(0, 1, 1, 0, '0, 0);
    step(0, 1, 1, 0, '0, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 1, 0, '0, 0);
      chk_flag("R6 stopped", 1'b0);
    end
    step(0, 1, 0, 0, '0, 0);
    step(0, 1, 1, 0, '0, 0);
    step(0, 1, 1, 0, '0, 0); chk_flag("R6 reload", 1'b0);
    step(0, 1, 1, 0, '0, 0); chk_flag("R6 full period", 1'b1);
    clear_all();

    // R3: direct switch from read wait to busy reloads
    step(1, 0, 0, 0, '0, 0);
    step(1, 0, 1, 0, '0, 0);
    step(1, 0, 1, 0, '0, 0);
    step(0, 1, 0, 0, '0, 0);
    step(0, 1, 1, 0, '0, 0);
    step(0, 1, 1, 0, '0, 0); chk_flag("R3 switch reload", 1'b0);
    step(0, 1, 1, 0, '0, 0); chk_flag("R3 switch expire", 1'b1);
    clear_all();

    // R10/R5: period 0, tick in entry cycle ignored
    step(0, 0, 0, 1, 32'd0, 0);
    step(1, 0, 1, 0, '0, 0); chk_flag("R10 entry tick", 1'b0);
    step(1, 0, 0, 0, '0, 0); chk_flag("R5 no tick", 1'b0);
    step(1, 0, 1, 0, '0, 0); chk_flag("R5 zero period", 1'b1);
    clear_all();

    // R8: write during count
    step(0, 0, 0, 1, 32'd5, 0);
    step(1, 0, 0, 0, '0, 0);
    step(1, 0, 1, 0, '0, 0);
    step(1, 0, 0, 1, 32'd1, 0);
    chk_rd("R8 new value", 32'd1);
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 1, 0, '0, 0);
      chk_flag("R8 count kept", 1'b0);
    end
    step(1, 0, 1, 0, '0, 0); chk_flag("R8 old period expire", 1'b1);
    clear_all();
    step(1, 0, 0, 0, '0, 0);
    step(1, 0, 1, 0, '0, 0); chk_flag("R8 next entry uses new", 1'b1);
    clear_all();

    // R8: write in entry cycle loads old value (old=1, new=4)
    step(1, 0, 0, 1, 32'd4, 0);
    step(1, 0, 1, 0, '0, 0); chk_flag("R8 entry+write old", 1'b1);
    clear_all();

    // R7: fire and clear together, period 1
    step(0, 0, 0, 1, 32'd1, 0);
    step(0, 1, 0, 0, '0, 0);
    step(0, 1, 1, 0, '0, 1); chk_flag("R7 set wins", 1'b1);
    step(0, 1, 0, 0, '0, 0); chk_flag("R7 sticky", 1'b1);
    clear_all();

    // random phase against the model
    rw = 1'b0; bz = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) rw = ~rw;
      if ($urandom_range(9) == 0) bz = ~bz;
      step(rw, bz, 1'($urandom_range(1)), ($urandom_range(11) == 0),
           32'($urandom_range(12)), ($urandom_range(15) == 0));
      chk_flag("R4 random", m_flag);
      chk_rd("R2 random", m_period);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule